// File: doc/BRIEF.md
# Stack Pointer Bounds Monitor

This block watches the stack pointer of every CPU core and raises a level interrupt once a stack leaves the address window that software has set up for it. Each core supplies its stack pointer, its program counter and a strobe that marks them valid. On each strobe the block samples the pair and compares the stack pointer, as an unsigned number, with two limit registers that belong to that core.

The block keeps two controls apart. A monitor mask decides whether a limit breach shows in the readable violation bits. A delivery mask decides whether that breach reaches the interrupt line. Software can therefore poll the violation bits without taking an interrupt. The interrupt state is held in internal flops that software cannot read. These flops follow the gated violation bits on every clock edge, and a write-one-to-clear pulse clears them for one cycle.

When recording is armed, the program counter that came with the offending sample is latched. A global status word names the lowest-numbered core that currently shows a violation.

Top module: `sp_bounds_monitor`

## Requirements
- R1: For each core, the high condition is true when the last sampled stack pointer is strictly greater than that core's upper limit. The low condition is true when it is strictly less than the lower limit. Both comparisons are unsigned, and a value equal to a limit triggers neither condition.
- R2: The violation word (offset 0x14, read-only) has bit 0 = low condition AND monitor-mask bit 0, and bit 1 = high condition AND monitor-mask bit 1. The monitor mask is at offset 0x08. A clear write does not change this word.
- R3: Each of a core's two interrupt-state flops loads (violation AND delivery mask) on every clock edge. The delivery mask is at offset 0x0C. A write to the clear register (offset 0x10) with a bit set forces that flop to 0 for that edge. The clear register always reads 0.
- R4: `irq_out` is the OR of all interrupt-state flops of all cores. With the monitor mask set and the delivery mask at 0, a violation leaves `irq_out` low.
- R5: The captured-PC register (offset 0x18, read-only) loads the sampled program counter when any violation bit of that core rises. Capture happens only if both bits 0 and 1 of the record register (offset 0x1C) are set. Otherwise the captured PC holds its value.
- R6: The status word at address 0x80 reads as the index of the lowest-numbered core with a nonzero violation word, or 0xFFFFFFFF when no core has one.
- R7: After reset, the lower limit (offset 0x00) reads 0, the upper limit (offset 0x04) reads 0xFFFFFFFF, the monitor mask, delivery mask, record register, captured PC and violation word read 0, and `irq_out` is low.
- R8: Each core has its own register set at byte base core×0x20. Writes to one core's set do not change any other core's registers.
- R9: The bus is one access per cycle with `bus_en`, and `bus_we` high for a write. Read data appears on `bus_rdata` in the cycle after the read, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_sp | input | NCORES*XLEN | Stack pointer of each core, core 0 in the low bits |
| core_pc | input | NCORES*XLEN | Program counter of each core |
| core_vld | input | NCORES | Sample strobe, one per core |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | High for a write, low for a read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | XLEN | Write data |
| bus_rdata | output | XLEN | Read data, one cycle after the read |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The bench places the stack pointer exactly on each limit and one step beyond it. A design with a non-strict comparison would report a violation at the limit. The bench also uses a value with the top bit set, which a signed comparison would misclassify as below the lower limit. Two more corner cases are covered: a clear write while the breach persists must drop the interrupt for exactly one cycle, and a breach that stays active must not overwrite the captured PC. A design with a sticky interrupt state, or one that records on the level of a violation rather than its rise, would fail these checks. Both cores are driven into violation together so that the status word must pick core 0 over core 1, and then core 1 once core 0 has recovered.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int N_COND = 2;
  localparam int COND_LO = 0;
  localparam int COND_HI = 1;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_LO  = 3'd0,
    IDX_HI  = 3'd1,
    IDX_MON = 3'd2,
    IDX_DLV = 3'd3,
    IDX_CLR = 3'd4,
    IDX_RAW = 3'd5,
    IDX_PC  = 3'd6,
    IDX_REC = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/sbm_limit_cmp.sv
module sbm_limit_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] sp,
  input  logic [XLEN-1:0] lim_lo,
  input  logic [XLEN-1:0] lim_hi,
  output logic [sbm_pkg::N_COND-1:0] cond
);
  always_comb begin
    cond = '0;
    cond[sbm_pkg::COND_LO] = sp < lim_lo;
    cond[sbm_pkg::COND_HI] = sp > lim_hi;
  end
endmodule

// File: rtl/sbm_fire_pick.sv
module sbm_fire_pick #(
  parameter int NCORES = 2,
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCORES-1:0] hit,
  output logic [XLEN-1:0]   fired
);
  always_comb begin
    fired = '1;
    for (int c = NCORES - 1; c >= 0; c--) begin
      if (hit[c]) fired = XLEN'(c);
    end
  end

  // R6: a core index is reported exactly when some core shows a violation
  a_r6_fired_consistent: assert property (@(posedge clk) disable iff (rst)
    ((hit != '0) == (fired != '1)));
endmodule

// File: rtl/sbm_core.sv
module sbm_core #(
  parameter int XLEN = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [XLEN-1:0]              sp_in,
  input  logic [XLEN-1:0]              pc_in,
  input  logic                         vld_in,
  input  logic                         wr_en,
  input  logic [sbm_pkg::IDX_W-1:0]    wr_idx,
  input  logic [XLEN-1:0]              wr_data,
  input  logic [sbm_pkg::IDX_W-1:0]    rd_idx,
  output logic [XLEN-1:0]              rd_data,
  output logic [sbm_pkg::N_COND-1:0]   raw_out,
  output logic                         irq_out
);
  import sbm_pkg::*;

  logic [XLEN-1:0]   lo_q, hi_q, sp_q, pc_q, pc_cap_q;
  logic [N_COND-1:0] mon_q, dlv_q, rec_q, raw_prev_q, state_q;
  logic [N_COND-1:0] cond, raw_v, clr_mask;
  logic              trig;

  sbm_limit_cmp #(.XLEN(XLEN)) u_cmp (
    .sp(sp_q), .lim_lo(lo_q), .lim_hi(hi_q), .cond(cond)
  );

  assign raw_v    = cond & mon_q;
  assign clr_mask = (wr_en && wr_idx == IDX_CLR) ? wr_data[N_COND-1:0] : '0;
  assign trig     = |(raw_v & ~raw_prev_q);

  // sampled stack pointer and program counter
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      pc_q <= '0;
    end else if (vld_in) begin
      sp_q <= sp_in;
      pc_q <= pc_in;
    end
  end

  // software-visible control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '1;
      mon_q <= '0;
      dlv_q <= '0;
      rec_q <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_LO:  lo_q  <= wr_data;
        IDX_HI:  hi_q  <= wr_data;
        IDX_MON: mon_q <= wr_data[N_COND-1:0];
        IDX_DLV: dlv_q <= wr_data[N_COND-1:0];
        IDX_REC: rec_q <= wr_data[N_COND-1:0];
        default: ;
      endcase
    end
  end

  // hidden interrupt state and PC capture
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= '0;
      raw_prev_q <= '0;
      pc_cap_q   <= '0;
    end else begin
      state_q    <= (raw_v & dlv_q) & ~clr_mask;
      raw_prev_q <= raw_v;
      if (trig && (&rec_q)) pc_cap_q <= pc_q;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      IDX_LO:  rd_data = lo_q;
      IDX_HI:  rd_data = hi_q;
      IDX_MON: rd_data[N_COND-1:0] = mon_q;
      IDX_DLV: rd_data[N_COND-1:0] = dlv_q;
      IDX_RAW: rd_data[N_COND-1:0] = raw_v;
      IDX_PC:  rd_data = pc_cap_q;
      IDX_REC: rd_data[N_COND-1:0] = rec_q;
      default: rd_data = '0;
    endcase
  end

  assign raw_out = raw_v;
  assign irq_out = |state_q;

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  // R3: a set state flop implies gated violation in the previous cycle
  a_r3_state_follows: assert property (@(posedge clk) disable iff (rst)
    ((state_q & ~$past(raw_v & dlv_q)) == '0));
  // R3: a clear pulse wins over a pending load
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (|$past(clr_mask)) |-> ((state_q & $past(clr_mask)) == '0));
  // R4: the interrupt needs a delivered violation one cycle earlier
  a_r4_irq_needs_dlv: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(raw_v & dlv_q) != '0));
  // R5: without a change of violation bits the captured PC holds
  a_r5_pc_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(raw_v) == $past(raw_v, 2)) |-> $stable(pc_cap_q));
endmodule

// File: rtl/sp_bounds_monitor.sv
module sp_bounds_monitor #(
  parameter int NCORES = 2,
  parameter int XLEN = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FIRED_ADDR = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCORES*XLEN-1:0] core_sp,
  input  logic [NCORES*XLEN-1:0] core_pc,
  input  logic [NCORES-1:0]      core_vld,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [XLEN-1:0]        bus_wdata,
  output logic [XLEN-1:0]        bus_rdata,
  output logic                   irq_out
);
  import sbm_pkg::*;

  localparam int STRIDE_LOG2 = IDX_W + 2;
  localparam int CSEL_W = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam int CORE_SPAN = NCORES << STRIDE_LOG2;

  logic [IDX_W-1:0]  idx;
  logic [CSEL_W-1:0] csel;
  logic              core_hit;
  logic [XLEN-1:0]   core_rd [NCORES];
  logic [NCORES-1:0] core_irq, core_any;
  logic [XLEN-1:0]   fired;

  assign idx      = bus_addr[STRIDE_LOG2-1:2];
  assign csel     = bus_addr[STRIDE_LOG2 +: CSEL_W];
  assign core_hit = int'(bus_addr) < CORE_SPAN;

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic [N_COND-1:0] raw_c;
    logic              we_c;
    assign we_c = bus_en && bus_we && core_hit && (int'(csel) == c);
    sbm_core #(.XLEN(XLEN)) u_core (
      .clk(clk), .rst(rst),
      .sp_in(core_sp[c*XLEN +: XLEN]),
      .pc_in(core_pc[c*XLEN +: XLEN]),
      .vld_in(core_vld[c]),
      .wr_en(we_c), .wr_idx(idx), .wr_data(bus_wdata),
      .rd_idx(idx), .rd_data(core_rd[c]),
      .raw_out(raw_c), .irq_out(core_irq[c])
    );
    assign core_any[c] = |raw_c;
  end

  sbm_fire_pick #(.NCORES(NCORES), .XLEN(XLEN)) u_pick (
    .clk(clk), .rst(rst), .hit(core_any), .fired(fired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      if (bus_addr == FIRED_ADDR) bus_rdata <= fired;
      else if (core_hit)          bus_rdata <= core_rd[csel];
      else                        bus_rdata <= '0;
    end
  end

  assign irq_out = |core_irq;

  logic unused_addr;
  assign unused_addr = ^bus_addr[1:0];
endmodule

// File: tb/sp_bounds_monitor_test.sv
module sp_bounds_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int XL = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [NC*XL-1:0] core_sp = '0, core_pc = '0;
  logic [NC-1:0] core_vld = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [XL-1:0] bus_wdata = '0, bus_rdata;
  logic irq_out;

  sp_bounds_monitor #(.NCORES(NC), .XLEN(XL), .ADDR_W(8)) uut (
    .clk(clk), .rst(rst), .core_sp(core_sp), .core_pc(core_pc),
    .core_vld(core_vld), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [XL-1:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  task automatic check(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data with scoreboard entries
  always @(posedge clk) rd_seen <= bus_en && !bus_we;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [XL-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [XL-1:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [XL-1:0] e, input string tag);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic sp_set(input int c, input logic [XL-1:0] sp, input logic [XL-1:0] pc);
    @(negedge clk);
    core_sp[c*XL +: XL] = sp; core_pc[c*XL +: XL] = pc; core_vld[c] = 1;
    @(negedge clk);
    core_vld[c] = 0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] ra(input int c, input int off);
    return 8'(c * 32 + off);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R7 reset state
    check("R7 irq after reset", irq_out, 0);
    rd(ra(0, 'h00), 32'h0, "R7 lower limit");
    rd(ra(0, 'h04), 32'hFFFF_FFFF, "R7 upper limit");
    rd(ra(0, 'h08), 32'h0, "R7 monitor mask");
    rd(ra(1, 'h14), 32'h0, "R7 violation word");
    rd(8'h80, 32'hFFFF_FFFF, "R6 status none fired");
    rd(8'h44, 32'h0, "R9 unmapped address");

    // R1 strict unsigned comparison, R4 polling without delivery
    wr(ra(0, 'h00), 32'h1000);
    wr(ra(0, 'h04), 32'h2000);
    wr(ra(0, 'h08), 32'h3);
    sp_set(0, 32'h2000, 32'h10);
    rd(ra(0, 'h14), 32'h0, "R1 equal upper limit");
    sp_set(0, 32'h1000, 32'h14);
    rd(ra(0, 'h14), 32'h0, "R1 equal lower limit");
    sp_set(0, 32'h2001, 32'h18);
    rd(ra(0, 'h14), 32'h2, "R1 above upper limit");
    check("R4 no irq without delivery", irq_out, 0);
    rd(8'h80, 32'h0, "R6 core 0 fired");
    sp_set(0, 32'h0FFF, 32'h1C);
    rd(ra(0, 'h14), 32'h1, "R1 below lower limit");
    sp_set(0, 32'h8000_0000, 32'h20);
    rd(ra(0, 'h14), 32'h2, "R1 unsigned top bit");
    // R2 monitor mask gates violation
    wr(ra(0, 'h08), 32'h1);
    sp_set(0, 32'h3000, 32'h24);
    rd(ra(0, 'h14), 32'h0, "R2 masked high condition");
    rd(ra(0, 'h18), 32'h0, "R5 no capture without record");

    // R5 capture on rising violation
    wr(ra(0, 'h1C), 32'h3);
    sp_set(0, 32'h1800, 32'h11);
    wr(ra(0, 'h08), 32'h3);
    wr(ra(0, 'h0C), 32'h3);
    check("R4 irq low in window", irq_out, 0);
    sp_set(0, 32'h2100, 32'hAAAA);
    check("R3 irq with delivery", irq_out, 1);
    rd(ra(0, 'h18), 32'hAAAA, "R5 captured pc");
    sp_set(0, 32'h2200, 32'hBBBB);
    rd(ra(0, 'h18), 32'hAAAA, "R5 pc held while active");

    // R3 clear pulse drops state for one cycle only
    wr(ra(0, 'h10), 32'h2);
    check("R3 clear drops irq", irq_out, 0);
    @(negedge clk);
    check("R3 state reloads after clear", irq_out, 1);
    rd(ra(0, 'h14), 32'h2, "R2 violation kept across clear");
    rd(ra(0, 'h10), 32'h0, "R3 clear reads zero");

    // R8 independence, R6 priority, R4 OR across cores
    wr(ra(1, 'h00), 32'h500);
    wr(ra(1, 'h08), 32'h3);
    wr(ra(1, 'h1C), 32'h1);
    wr(ra(0, 'h0C), 32'h0);
    sp_set(1, 32'h400, 32'h77);
    rd(8'h80, 32'h0, "R6 lowest core wins");
    check("R4 no irq without delivery on either core", irq_out, 0);
    rd(ra(1, 'h18), 32'h0, "R5 partial record bits");
    rd(ra(1, 'h04), 32'hFFFF_FFFF, "R8 core 1 upper limit untouched");
    rd(ra(0, 'h00), 32'h1000, "R8 core 0 lower limit untouched");
    sp_set(0, 32'h1800, 32'h30);
    rd(8'h80, 32'h1, "R6 core 1 after core 0 recovers");
    wr(ra(1, 'h0C), 32'h1);
    @(negedge clk);
    check("R4 irq from core 1", irq_out, 1);
    wr(ra(1, 'h1C), 32'h3);
    sp_set(1, 32'h600, 32'h88);
    check("R4 irq drops in window", irq_out, 0);
    sp_set(1, 32'h300, 32'h99);
    rd(ra(1, 'h18), 32'h99, "R5 core 1 capture");
    rd(ra(0, 'h18), 32'hAAAA, "R8 core 0 pc unaffected");
    wr(ra(1, 'h08), 32'h0);
    rd(8'h80, 32'hFFFF_FFFF, "R6 none after disable");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule